// File: doc/BRIEF.md
# Page-Mode Burst Read Sequencer

This block performs byte reads on an 8-bit external bus whose address and data lines are separate. A request carries a start address, a page flag, a page-length code, and four timing values. With the page flag set, one request becomes a complete page read. The first byte uses the normal asynchronous read timing. Each following byte arrives after a short, fixed beat time. The chip select and the read strobe stay low for the whole page.

Each captured byte appears at the output with a one-cycle valid pulse. A done pulse marks the last byte. After the done pulse, the block keeps a configurable number of idle cycles before it will take another request. All timing is counted in cycles of the bus clock `clk`. A page request with the length code reserved for continuous bursts is refused at once.

Top module: `page_read_seq`

## Requirements
- R1: When `busy` is low, a `req_valid` on a rising edge is accepted, except for a refused request (R9), and `bus_cs_n` goes low in the next cycle. Cycle index 0 is the first cycle with chip select low. `busy` stays high from index 0 until the idle gap of R10 ends.
- R2: `bus_rd_n` first goes low at index `cfg_oe_dly`; a delay of 0 lowers it together with chip select. The first byte is sampled from `mem_din` at the end of index E, where E = max(`cfg_rd_ws`, `cfg_oe_dly`). The first strobe is therefore E − `cfg_oe_dly` + 1 cycles wide.
- R3: With `req_page` = 1, the code `req_len` gives the page size: 2'b00 is 4 bytes, 2'b01 is 8 bytes and 2'b10 is 16 bytes. With `req_page` = 0, exactly one byte is read and `req_len` is ignored.
- R4: Every byte after the first takes 1 + `cfg_burst_ws` cycles. So a page of N bytes holds chip select low for T = E + 1 + (N − 1)(1 + `cfg_burst_ws`) cycles.
- R5: Once `bus_rd_n` is low, it stays low until chip select rises. The two signals rise on the same edge, at index T. `bus_rd_n` is never low while `bus_cs_n` is high.
- R6: Byte k of a page is read from address (A & ~M) | ((A + k) & M). Here A is the start address and M is the page size minus 1, so the address wraps inside the aligned page. The address changes only on the edge that captures a byte.
- R7: Each byte is presented on `beat_data` with a one-cycle `beat_valid`. This happens in the cycle after the edge that sampled it, at index E + 1 + k(1 + `cfg_burst_ws`) for byte k.
- R8: `done` is high for exactly one cycle, at index T, together with the `beat_valid` of the last byte.
- R9: A request with `req_page` = 1 and `req_len` = 2'b11 is refused. `req_err` pulses for one cycle in the next cycle, and chip select, read strobe and `busy` stay inactive.
- R10: After `done`, `busy` stays high for `cfg_idle` further cycles and is low from index T + `cfg_idle` onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 16 | Start byte address |
| req_page | input | 1 | 1 = page read, 0 = single read |
| req_len | input | 2 | Page-length code |
| cfg_oe_dly | input | 5 | Cycles from chip select to the first strobe |
| cfg_rd_ws | input | 5 | Cycle index of the first-byte sample |
| cfg_burst_ws | input | 5 | Extra cycles per following byte |
| cfg_idle | input | 4 | Idle cycles after a page |
| mem_din | input | 8 | External data bus |
| busy | output | 1 | A request would not be accepted |
| req_err | output | 1 | Request refused (reserved code) |
| bus_addr | output | 16 | External address bus |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| beat_valid | output | 1 | Captured byte valid |
| beat_data | output | 8 | Captured byte |
| done | output | 1 | Last byte of the request |

## Verification
The assertions check the bus-level properties on every cycle:
- the strobe is never active without chip select, and it is held low until both rise together;
- the address moves only on a capture cycle;
- `done` is a single pulse that comes with the last byte;
- a refusal never starts a bus cycle.

The exact cycle positions need a scenario with known settings. These are the strobe delay, the first-sample index, the per-byte spacing, the page length, the address wrap and the length of the idle gap. The bench compares each of them against values it computes from the request and its settings.

// File: rtl/page_read_pkg.sv
// Shared types for the page-mode read sequencer.
// Assumes: nothing beyond the types defined here.
package page_read_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FIRST = 2'd1,
        SEQ_BEAT  = 2'd2
    } seq_state_t;

    localparam logic [1:0] LEN_RESERVED = 2'b11;
endpackage

// File: rtl/page_addr_step.sv
// Next address inside an aligned page of (4 << len_code) bytes.
// Assumes: len_code is not the reserved value when it is used.
module page_addr_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [1:0]    len_code,
    output logic [AW-1:0] next_addr
);
    logic [AW-1:0] wrap_mask;
    logic [AW-1:0] plus_one;

    // Build the in-page mask and keep the upper bits fixed.
    always_comb begin
        wrap_mask = (AW'(4) << len_code) - AW'(1);
        plus_one  = cur_addr + AW'(1);
        next_addr = (cur_addr & ~wrap_mask) | (plus_one & wrap_mask);
    end
endmodule

// File: rtl/page_gap_timer.sv
// Counts the idle cycles that must follow a finished request.
// Assumes: start is a single-cycle pulse on the last capture edge.
module page_gap_timer #(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] gap_len,
    output logic          gap_active
);
    logic [IW-1:0] remain_q;

    // Load the gap length on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                remain_q <= '0;
        else if (start)            remain_q <= gap_len;
        else if (remain_q != '0)   remain_q <= remain_q - IW'(1);
    end

    assign gap_active = (remain_q != '0);
endmodule

// File: rtl/page_read_seq.sv
// Page-mode read sequencer for an 8-bit bus with separate address and data lines.
// A request is followed by one asynchronous first access, then (in page mode)
// more bytes at 1 + burst wait cycles each, with chip select and strobe held low.
// Assumes: mem_din is stable at the sampling edge; all settings are latched
// when the request is accepted.
module page_read_seq
    import page_read_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int TW  = 5,
    parameter int IW  = 4,
    parameter int MAX_BEATS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_page,
    input  logic [1:0]    req_len,
    input  logic [TW-1:0] cfg_oe_dly,
    input  logic [TW-1:0] cfg_rd_ws,
    input  logic [TW-1:0] cfg_burst_ws,
    input  logic [IW-1:0] cfg_idle,
    input  logic [DW-1:0] mem_din,
    output logic          busy,
    output logic          req_err,
    output logic [AW-1:0] bus_addr,
    output logic          bus_cs_n,
    output logic          bus_rd_n,
    output logic          beat_valid,
    output logic [DW-1:0] beat_data,
    output logic          done
);
    localparam int BW = $clog2(MAX_BEATS + 1);

    seq_state_t    state_q;
    logic [TW-1:0] cnt_q;
    logic [TW-1:0] oe_q, end_q, bws_q;
    logic [IW-1:0] idle_q;
    logic [1:0]    len_q;
    logic [BW-1:0] left_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_nxt;
    logic          gap_active;
    logic          can_take, refuse, accept, capture, last_beat;
    logic [BW-1:0] start_beats;

    page_addr_step #(.AW(AW)) u_step (
        .cur_addr  (addr_q),
        .len_code  (len_q),
        .next_addr (addr_nxt)
    );

    page_gap_timer #(.IW(IW)) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (capture && last_beat),
        .gap_len    (idle_q),
        .gap_active (gap_active)
    );

    // Request decode: accept, refuse, and the number of bytes to read.
    always_comb begin
        can_take    = (state_q == SEQ_IDLE) && !gap_active;
        refuse      = can_take && req_valid && req_page && (req_len == LEN_RESERVED);
        accept      = can_take && req_valid && !refuse;
        start_beats = req_page ? (BW'(4) << req_len) : BW'(1);
    end

    // Capture condition for the current byte.
    always_comb begin
        capture   = ((state_q == SEQ_FIRST) && (cnt_q == end_q)) ||
                    ((state_q == SEQ_BEAT)  && (cnt_q == bws_q));
        last_beat = (left_q == BW'(1));
    end

    // Main sequencer: state, timing counter, address and byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            oe_q    <= '0;
            end_q   <= '0;
            bws_q   <= '0;
            idle_q  <= '0;
            len_q   <= '0;
            left_q  <= '0;
            addr_q  <= '0;
        end else if (accept) begin
            state_q <= SEQ_FIRST;
            cnt_q   <= '0;
            oe_q    <= cfg_oe_dly;
            end_q   <= (cfg_rd_ws >= cfg_oe_dly) ? cfg_rd_ws : cfg_oe_dly;
            bws_q   <= cfg_burst_ws;
            idle_q  <= cfg_idle;
            len_q   <= req_page ? req_len : 2'b00;
            left_q  <= start_beats;
            addr_q  <= req_addr;
        end else if (capture) begin
            left_q <= left_q - BW'(1);
            cnt_q  <= '0;
            if (last_beat) begin
                state_q <= SEQ_IDLE;
            end else begin
                state_q <= SEQ_BEAT;
                addr_q  <= addr_nxt;
            end
        end else if (state_q != SEQ_IDLE) begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

    // Output pulses: captured byte, done and refusal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_valid <= 1'b0;
            beat_data  <= '0;
            done       <= 1'b0;
            req_err    <= 1'b0;
        end else begin
            beat_valid <= capture;
            done       <= capture && last_beat;
            req_err    <= refuse;
            if (capture) beat_data <= mem_din;
        end
    end

    // Bus pins follow the registered state.
    always_comb begin
        bus_addr = addr_q;
        bus_cs_n = (state_q == SEQ_IDLE);
        bus_rd_n = !(((state_q == SEQ_FIRST) && (cnt_q >= oe_q)) || (state_q == SEQ_BEAT));
        busy     = (state_q != SEQ_IDLE) || gap_active;
    end
endmodule

// File: rtl/page_read_seq_chk.sv
// Bus-level properties of the page-mode read sequencer, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module page_read_seq_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_cs_n,
    input logic          bus_rd_n,
    input logic          beat_valid,
    input logic [DW-1:0] beat_data,
    input logic          done,
    input logic          req_err,
    input logic          busy
);
    // R5
    strobe_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_cs_n);
    // R5
    strobe_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |=> (bus_rd_n == bus_cs_n));
    // R6
    addr_moves_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !$past(bus_cs_n) && (bus_addr != $past(bus_addr))) |-> beat_valid);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_with_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> beat_valid);
    // R9
    refusal_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (bus_cs_n && bus_rd_n && !busy));
endmodule

bind page_read_seq page_read_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_cs_n   (bus_cs_n),
    .bus_rd_n   (bus_rd_n),
    .beat_valid (beat_valid),
    .beat_data  (beat_data),
    .done       (done),
    .req_err    (req_err),
    .busy       (busy)
);

// File: tb/page_read_seq_bench.sv
module page_read_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_page = 1'b0;
    logic [1:0]  req_len = '0;
    logic [4:0]  cfg_oe_dly = '0, cfg_rd_ws = '0, cfg_burst_ws = '0;
    logic [3:0]  cfg_idle = '0;
    logic [7:0]  mem_din;
    logic        busy, req_err, bus_cs_n, bus_rd_n, beat_valid, done;
    logic [15:0] bus_addr;
    logic [7:0]  beat_data;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    page_read_seq u_page_read_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_page(req_page), .req_len(req_len), .cfg_oe_dly(cfg_oe_dly),
        .cfg_rd_ws(cfg_rd_ws), .cfg_burst_ws(cfg_burst_ws), .cfg_idle(cfg_idle),
        .mem_din(mem_din), .busy(busy), .req_err(req_err), .bus_addr(bus_addr),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .beat_valid(beat_valid),
        .beat_data(beat_data), .done(done)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    function automatic logic [15:0] beat_addr(input logic [15:0] a, input int sz, input int k);
        logic [15:0] m;
        m = 16'(sz - 1);
        return (a & ~m) | (16'(a + 16'(k)) & m);
    endfunction

    assign mem_din = !bus_rd_n ? mem_byte(bus_addr) : 8'h00;

    task automatic check(input string rq, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic run_req(input logic [15:0] a, input bit pg, input logic [1:0] ln,
                           input int oe, input int rws, input int bws, input int idl);
        int n, e, t, k;
        n = pg ? (4 << ln) : 1;
        e = (rws >= oe) ? rws : oe;
        t = e + 1 + (n - 1) * (1 + bws);
        k = 0;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_page = pg; req_len = ln;
        cfg_oe_dly = 5'(oe); cfg_rd_ws = 5'(rws); cfg_burst_ws = 5'(bws); cfg_idle = 4'(idl);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        for (int idx = 0; idx <= t + idl; idx++) begin
            bit ev;
            ev = (idx >= e + 1) && (((idx - e - 1) % (1 + bws)) == 0) && (k < n);
            check("R1", "cs_n", int'(bus_cs_n), (idx < t) ? 0 : 1);
            check("R2/R5", "rd_n", int'(bus_rd_n), (idx >= oe && idx < t) ? 0 : 1);
            check("R7/R4", "beat_valid", int'(beat_valid), int'(ev));
            check("R8", "done", int'(done), (idx == t) ? 1 : 0);
            check("R10", "busy", int'(busy), (idx < t + idl) ? 1 : 0);
            if (ev && beat_valid) begin
                check("R6", "beat_data", int'(beat_data), int'(mem_byte(beat_addr(a, n, k))));
                k++;
            end
            if (idx < t + idl) @(negedge clk);
        end
        check("R3", "byte count", k, n);
    endtask

    task automatic run_refuse(input logic [15:0] a);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_page = 1; req_len = 2'b11;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        check("R9", "req_err", int'(req_err), 1);
        check("R9", "cs_n", int'(bus_cs_n), 1);
        check("R9", "busy", int'(busy), 0);
        @(negedge clk);
        check("R9", "req_err drop", int'(req_err), 0);
        check("R9", "rd_n", int'(bus_rd_n), 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1", "reset cs_n", int'(bus_cs_n), 1);
        check("R5", "reset rd_n", int'(bus_rd_n), 1);
        check("R1", "reset busy", int'(busy), 0);
        check("R7", "reset valid", int'(beat_valid), 0);
        check("R8", "reset done", int'(done), 0);
        // R2 strobe with chip select, minimal timing
        run_req(16'h1000, 1, 2'b00, 0, 0, 0, 0);
        // R3 single read ignores length code
        run_req(16'h2345, 0, 2'b10, 2, 3, 1, 2);
        // R6 wrap inside a 16-byte page
        run_req(16'h40FD, 1, 2'b10, 1, 1, 0, 3);
        // R6 wrap inside an 8-byte page with burst wait
        run_req(16'h7776, 1, 2'b01, 1, 4, 2, 1);
        // R2 wait state below delay
        run_req(16'h0003, 1, 2'b00, 3, 1, 1, 0);
        // R9 reserved code refused in page mode
        run_refuse(16'h5555);
        // R3 reserved code allowed for single read
        run_req(16'h5555, 0, 2'b11, 0, 2, 0, 1);
        for (int i = 0; i < 40; i++) begin
            logic [1:0] ln;
            ln = 2'($urandom_range(0, 2));
            run_req(16'($urandom), 1'($urandom_range(0, 1)), ln,
                    $urandom_range(0, 3), $urandom_range(0, 6),
                    $urandom_range(0, 3), $urandom_range(0, 4));
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule